// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the master side of a two-wire PHY management interface. A single start pulse, together with a read/write select, a 5-bit PHY address, a 5-bit register address and 16 bits of write data, launches one complete management frame. The block generates the management clock (MDC) from the system clock through a half-period divider. It drives the data line through separate data-out and output-enable signals, so that the pad logic outside can release the line while the PHY answers.

Every frame opens with an extended preamble of 40 driven ones, followed by the start and opcode pairs and the two address fields. A read releases the line for a single turnaround clock. It then captures 16 bits from the PHY, most significant first, and completes after one extra clock. A write drives its turnaround actively as one then zero and sends 16 data bits. It then releases the line for one trailing clock. A one-cycle done pulse marks the end of the frame, and on a read the captured word is on the read-data output at that point.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset (synchronous, active low) mdc_o is 0, mdio_oe_o is 0, busy_o is 0 and done_o is 0.
- R2: Every frame begins with 40 MDC cycles during which mdio_oe_o is 1 and mdio_o is 1.
- R3: After the preamble come the start pair 0,1 and the opcode pair, which is 1,0 for a read (rd_i=1) and 0,1 for a write (rd_i=0), all driven.
- R4: The PHY address and then the register address follow, 5 bits each, most significant bit first, driven.
- R5: Each MDC high and low phase lasts exactly CLK_DIV system clocks. mdio_o and mdio_oe_o change only while MDC is low, so they are stable at every MDC rising edge.
- R6: On a read, mdio_oe_o is 0 from the turnaround clock onward. After the single turnaround clock, 16 bits are sampled from mdio_i as MDC falls, most significant first, and presented on rdata_o when done_o pulses.
- R7: On a write, the two turnaround clocks carry 1 then 0, driven. They are followed by the 16 bits of wdata_i, most significant first, driven.
- R8: Every frame ends with one trailing MDC cycle with mdio_oe_o at 0. A read frame therefore has 72 MDC cycles and a write frame has 73, and done_o rises 2*CLK_DIV*cycles+1 clocks after the clock that accepts the start.
- R9: busy_o is 1 from the clock after the start pulse until done_o. done_o is a one-cycle pulse in the clock where busy_o falls.
- R10: A start pulse that arrives while busy_o is 1 is ignored: the running frame, its bit pattern and its result are unchanged, and only one done_o pulse results.
- R11: Between frames MDC stays low and mdio_oe_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to launch a frame |
| rd_i | input | 1 | 1 selects a read frame, 0 a write frame |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register address |
| wdata_i | input | 16 | Data sent by a write frame |
| rdata_o | output | 16 | Word captured by the last read frame |
| done_o | output | 1 | One-cycle pulse at frame completion |
| busy_o | output | 1 | Frame in progress |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data value to drive on the management line |
| mdio_oe_o | output | 1 | Output enable for the management line pad |
| mdio_i | input | 1 | Value read back from the management line |

## Verification
A wrong slot counter or field decode shows up at the very next MDC rising edge as a misplaced bit or a wrongly timed output enable. The bench captures every rising edge of a frame and compares it with a pattern it builds from the requirements. A divider fault stretches or shortens an MDC phase, which is caught at the following falling edge and again in the total clock count to done. A sequencer that loses track of busy either accepts a second start, which corrupts the captured pattern within one MDC cycle, or never finishes. A missing done is caught by the bounded wait in each scenario.

// File: rtl/mdio_pkg.sv
// Package: shared field widths and the latched command record for the
// management frame master. Assumes clause-22 field sizes.
package mdio_pkg;
    localparam int PHY_AW = 5;
    localparam int REG_AW = 5;
    localparam int DATA_W = 16;

    // One management request, held for the life of a frame
    typedef struct packed {
        logic                  rd;
        logic [PHY_AW-1:0]     phy;
        logic [REG_AW-1:0]     regad;
        logic [DATA_W-1:0]     wdata;
    } mdio_cmd_t;
endpackage

// File: rtl/mdio_half_timer.sv
// Module: half-period timer. Emits one tick every CLK_DIV clocks while
// run is high and restarts from zero whenever run is low.
// Assumes CLK_DIV >= 1.
module mdio_half_timer #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

    logic [CW-1:0] cnt;

    // Count clocks within one half-period; clear while idle
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

    generate
        if (CLK_DIV > 1) begin : g_len_chk
            // R5
            half_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/mdio_field_mux.sv
// Module: slot decoder. For a frame slot index it gives the bit to drive,
// the output enable, whether the slot samples read data, and whether it
// is the final trailing slot. Purely combinational.
// Assumes PRE >= 1 and SW wide enough for PRE+33.
module mdio_field_mux
    import mdio_pkg::*;
#(
    parameter int PRE = 40,
    parameter int SW  = 7
) (
    input  logic [SW-1:0] slot_i,
    input  mdio_cmd_t     cmd_i,
    output logic          bit_o,
    output logic          en_o,
    output logic          rx_o,
    output logic          last_o
);
    localparam int ST = PRE;        // start pair
    localparam int OP = PRE + 2;    // opcode pair
    localparam int PA = PRE + 4;    // phy address
    localparam int RA = PRE + 9;    // register address
    localparam int TA = PRE + 14;   // turnaround
    localparam int RD = PRE + 15;   // read data
    localparam int WD = PRE + 16;   // write data
    localparam int TR_R = RD + DATA_W;
    localparam int TR_W = WD + DATA_W;

    int         s_i;
    logic [2:0] pidx;
    logic [2:0] ridx;
    logic [3:0] didx;

    assign s_i  = int'(slot_i);
    assign pidx = 3'(PHY_AW - 1 - (s_i - PA));
    assign ridx = 3'(REG_AW - 1 - (s_i - RA));
    assign didx = 4'(DATA_W - 1 - (s_i - WD));

    // Map the slot index onto the frame field it belongs to
    always_comb begin
        bit_o  = 1'b0;
        en_o   = 1'b0;
        rx_o   = 1'b0;
        last_o = 1'b0;
        if (s_i < ST) begin
            bit_o = 1'b1;
            en_o  = 1'b1;
        end else if (s_i < OP) begin
            en_o  = 1'b1;
            bit_o = (s_i == ST + 1);
        end else if (s_i < PA) begin
            en_o  = 1'b1;
            bit_o = (s_i == OP) ? cmd_i.rd : !cmd_i.rd;
        end else if (s_i < RA) begin
            en_o  = 1'b1;
            bit_o = cmd_i.phy[pidx];
        end else if (s_i < TA) begin
            en_o  = 1'b1;
            bit_o = cmd_i.regad[ridx];
        end else if (cmd_i.rd) begin
            if (s_i >= RD && s_i < TR_R) begin
                rx_o = 1'b1;
            end
            last_o = (s_i == TR_R);
        end else begin
            if (s_i < WD) begin
                en_o  = 1'b1;
                bit_o = (s_i == TA);
            end else if (s_i < TR_W) begin
                en_o  = 1'b1;
                bit_o = cmd_i.wdata[didx];
            end
            last_o = (s_i == TR_W);
        end
    end
endmodule

// File: rtl/mdio_rx_shift.sv
// Module: read-data shifter. Clears on request and shifts in one bit,
// most significant first, on each sample strobe.
module mdio_rx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         sample,
    input  logic         bit_i,
    output logic [W-1:0] data_o
);
    // Accumulate sampled line bits, oldest at the top
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            data_o <= '0;
        end else if (sample) begin
            data_o <= {data_o[W-2:0], bit_i};
        end
    end
endmodule

// File: rtl/mdio_frame_master.sv
// Module: management frame master top. Latches a request on start_i,
// walks the frame slot by slot, one MDC cycle per slot (low half then
// high half), and drives MDC, data and output enable from registers.
// Assumes mdio_i is already synchronous to clk.
module mdio_frame_master
    import mdio_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int PRE     = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 rd_i,
    input  logic [PHY_AW-1:0]    phy_addr_i,
    input  logic [REG_AW-1:0]    reg_addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    rdata_o,
    output logic                 done_o,
    output logic                 busy_o,
    output logic                 mdc_o,
    output logic                 mdio_o,
    output logic                 mdio_oe_o,
    input  logic                 mdio_i
);
    localparam int MAX_SLOT = PRE + 2 + 2 + PHY_AW + REG_AW + 2 + DATA_W;
    localparam int SW = $clog2(MAX_SLOT + 2);

    mdio_cmd_t   cmd;
    logic [SW-1:0] slot;
    logic [SW-1:0] slot_nx;
    logic        high_half;
    logic        tick;
    logic        cur_bit, cur_en, cur_rx, cur_last;
    logic        nx_bit, nx_en, nx_rx, nx_last;
    logic        accept;

    assign accept  = start_i && !busy_o;
    assign slot_nx = slot + 1'b1;

    mdio_half_timer #(.CLK_DIV(CLK_DIV)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy_o),
        .tick (tick)
    );

    mdio_field_mux #(.PRE(PRE), .SW(SW)) u_cur (
        .slot_i(slot),
        .cmd_i (cmd),
        .bit_o (cur_bit),
        .en_o  (cur_en),
        .rx_o  (cur_rx),
        .last_o(cur_last)
    );

    mdio_field_mux #(.PRE(PRE), .SW(SW)) u_nxt (
        .slot_i(slot_nx),
        .cmd_i (cmd),
        .bit_o (nx_bit),
        .en_o  (nx_en),
        .rx_o  (nx_rx),
        .last_o(nx_last)
    );

    mdio_rx_shift #(.W(DATA_W)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .sample(busy_o && tick && high_half && cur_rx),
        .bit_i (mdio_i),
        .data_o(rdata_o)
    );

    // Frame sequencer: accept a request, then step MDC phases and slots
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd       <= '0;
            slot      <= '0;
            high_half <= 1'b0;
            busy_o    <= 1'b0;
            done_o    <= 1'b0;
            mdc_o     <= 1'b0;
            mdio_o    <= 1'b0;
            mdio_oe_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (accept) begin
                cmd       <= '{rd: rd_i, phy: phy_addr_i, regad: reg_addr_i, wdata: wdata_i};
                slot      <= '0;
                high_half <= 1'b0;
                busy_o    <= 1'b1;
                mdc_o     <= 1'b0;
                mdio_o    <= 1'b1;
                mdio_oe_o <= 1'b1;
            end else if (busy_o && tick) begin
                if (!high_half) begin
                    mdc_o     <= 1'b1;
                    high_half <= 1'b1;
                end else begin
                    mdc_o     <= 1'b0;
                    high_half <= 1'b0;
                    if (cur_last) begin
                        busy_o    <= 1'b0;
                        done_o    <= 1'b1;
                        mdio_o    <= 1'b0;
                        mdio_oe_o <= 1'b0;
                    end else begin
                        slot      <= slot_nx;
                        mdio_o    <= nx_bit;
                        mdio_oe_o <= nx_en;
                    end
                end
            end
        end
    end

    // R5
    mdc_stable_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdc_o |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mdc_o && !mdio_oe_o));

    // R9
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (int'(slot) <= MAX_SLOT));

    // R6
    rx_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cur_rx) |-> !mdio_oe_o);

    // R10
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !done_o) |=> (busy_o || done_o));

    // Decoder outputs of the look-ahead copy are only partly consumed
    logic unused_ok;
    assign unused_ok = &{1'b0, cur_bit, cur_en, nx_rx, nx_last};
endmodule

// File: tb/mdio_frame_master_bench.sv
// Bench: directed scenarios, one task each, checking frames captured at
// every MDC rising edge against patterns built from the requirements.
module mdio_frame_master_bench;
    localparam int DIV = 2;
    localparam int PRE = 40;
    localparam int MAXR = 96;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        rd_i = 1'b0;
    logic [4:0]  phy_addr_i = '0;
    logic [4:0]  reg_addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic [15:0] rdata_o;
    logic        done_o, busy_o, mdc_o, mdio_o, mdio_oe_o;
    logic        mdio_i = 1'b1;

    int errors = 0;
    int checks = 0;

    logic        cap_bit [MAXR];
    logic        cap_en  [MAXR];
    logic        exp_bit [MAXR];
    logic        exp_en  [MAXR];
    int          exp_len;
    int          rise_n = 0;
    logic        phy_rd = 1'b0;
    logic [15:0] phy_val = '0;
    int          hi_cnt = 0;
    int          done_cnt = 0;

    always #2.5 clk = ~clk;

    mdio_frame_master #(.CLK_DIV(DIV), .PRE(PRE)) u_mdio_frame_master (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i),
        .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .done_o(done_o), .busy_o(busy_o), .mdc_o(mdc_o),
        .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Capture line state at each MDC rise; act as PHY for read data
    always @(posedge mdc_o) begin
        if (rise_n < MAXR) begin
            cap_bit[rise_n] = mdio_o;
            cap_en[rise_n]  = mdio_oe_o;
        end
        if (phy_rd && rise_n >= PRE + 15 && rise_n < PRE + 31)
            mdio_i = phy_val[15 - (rise_n - (PRE + 15))];
        else
            mdio_i = 1'b1;
        rise_n++;
    end

    // R5: each MDC high phase lasts DIV clocks; count done pulses
    always @(negedge clk) begin
        if (done_o) done_cnt++;
        if (mdc_o) hi_cnt++;
        else if (hi_cnt != 0) begin
            check("R5 mdc high length", hi_cnt, DIV);
            hi_cnt = 0;
        end
    end

    task automatic push(input logic b, input logic e);
        exp_bit[exp_len] = b;
        exp_en[exp_len]  = e;
        exp_len++;
    endtask

    task automatic build_exp(input logic rd, input logic [4:0] pa,
                             input logic [4:0] ra, input logic [15:0] wd);
        exp_len = 0;
        repeat (PRE) push(1'b1, 1'b1);
        push(1'b0, 1'b1); push(1'b1, 1'b1);
        push(rd, 1'b1);   push(!rd, 1'b1);
        for (int i = 4; i >= 0; i--) push(pa[i], 1'b1);
        for (int i = 4; i >= 0; i--) push(ra[i], 1'b1);
        if (rd) begin
            push(1'b0, 1'b0);
            repeat (16) push(1'b0, 1'b0);
        end else begin
            push(1'b1, 1'b1); push(1'b0, 1'b1);
            for (int i = 15; i >= 0; i--) push(wd[i], 1'b1);
        end
        push(1'b0, 1'b0);
    endtask

    task automatic cmp_range(input int lo, input int hi, input string tag);
        int bad = 0;
        int at  = 0;
        checks++;
        for (int i = lo; i < hi; i++) begin
            if (bad == 0 && (cap_en[i] !== exp_en[i] ||
                (exp_en[i] && cap_bit[i] !== exp_bit[i]))) begin
                bad = 1;
                at  = i;
            end
        end
        if (bad != 0) begin
            errors++;
            $display("FAIL %s: slot %0d actual en=%0b bit=%0b expected en=%0b bit=%0b",
                     tag, at, cap_en[at], cap_bit[at], exp_en[at], exp_bit[at]);
        end
    endtask

    task automatic launch(input logic rd, input logic [4:0] pa,
                          input logic [4:0] ra, input logic [15:0] wd,
                          output int cycles);
        rise_n  = 0;
        phy_rd  = rd;
        @(negedge clk);
        rd_i = rd; phy_addr_i = pa; reg_addr_i = ra; wdata_i = wd;
        start_i = 1'b1;
        cycles = 0;
        do begin
            @(negedge clk);
            start_i = 1'b0;
            cycles++;
        end while (!done_o && cycles < 5000);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 mdc after reset", int'(mdc_o), 0);
        check("R1 oe after reset", int'(mdio_oe_o), 0);
        check("R1 busy after reset", int'(busy_o), 0);
        check("R1 done after reset", int'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_write(input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] wd);
        int cyc;
        build_exp(1'b0, pa, ra, wd);
        launch(1'b0, pa, ra, wd, cyc);
        check("R8 write clocks to done", cyc, 2 * DIV * 73 + 1);
        check("R8 write mdc cycles", rise_n, 73);
        cmp_range(0, PRE, "R2 preamble");
        cmp_range(PRE, PRE + 4, "R3 start and write opcode");
        cmp_range(PRE + 4, PRE + 14, "R4 addresses");
        cmp_range(PRE + 14, PRE + 32, "R7 turnaround and data");
        cmp_range(PRE + 32, PRE + 33, "R8 trailing released");
    endtask

    task automatic t_read(input logic [4:0] pa, input logic [4:0] ra,
                          input logic [15:0] val);
        int cyc;
        phy_val = val;
        build_exp(1'b1, pa, ra, 16'h0);
        launch(1'b1, pa, ra, 16'hFFFF, cyc);
        check("R8 read clocks to done", cyc, 2 * DIV * 72 + 1);
        check("R8 read mdc cycles", rise_n, 72);
        check("R6 read data", int'(rdata_o), int'(val));
        cmp_range(PRE, PRE + 4, "R3 start and read opcode");
        cmp_range(PRE + 4, PRE + 14, "R4 addresses");
        cmp_range(PRE + 14, PRE + 31, "R6 released during read");
        cmp_range(PRE + 31, PRE + 32, "R8 trailing released");
    endtask

    task automatic t_busy_ignore;
        int cyc = 0;
        int d0;
        phy_val = 16'hA5C3;
        phy_rd  = 1'b1;
        rise_n  = 0;
        build_exp(1'b1, 5'h0B, 5'h1E, 16'h0);
        d0 = done_cnt;
        @(negedge clk);
        rd_i = 1'b1; phy_addr_i = 5'h0B; reg_addr_i = 5'h1E; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R9 busy after start", int'(busy_o), 1);
        while (rise_n < 20) @(negedge clk);
        rd_i = 1'b0; phy_addr_i = 5'h15; reg_addr_i = 5'h01; wdata_i = 16'h0F0F;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        check("R9 busy low at done", int'(busy_o), 0);
        cmp_range(0, 72, "R10 frame unchanged by late start");
        check("R10 read result kept", int'(rdata_o), 16'hA5C3);
        @(negedge clk);
        check("R9 done single pulse", int'(done_o), 0);
        repeat (300) @(negedge clk);
        check("R10 only one done", done_cnt - d0, 1);
    endtask

    task automatic t_idle;
        int r0 = rise_n;
        int bad = 0;
        repeat (40) begin
            @(negedge clk);
            if (mdc_o || mdio_oe_o || busy_o) bad++;
        end
        check("R11 quiet between frames", bad, 0);
        check("R11 no mdc edges while idle", rise_n, r0);
    endtask

    initial begin
        t_reset;
        t_write(5'h11, 5'h0A, 16'hBEEF);
        t_idle;
        t_write(5'h00, 5'h1F, 16'h0001);
        t_read(5'h1F, 5'h00, 16'h8001);
        t_read(5'h05, 5'h12, 16'h6A35);
        t_idle;
        t_busy_ignore;
        t_reset;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule